// File: doc/BRIEF.md
# Register Window Control Unit

This unit holds the window pointer and the window-occupancy mask for a windowed general register file. The pointer counts in steps of four physical registers and wraps modulo the number of window positions. The mask has one bit per position and marks which positions hold a live call frame. The unit carries out the window operations of the instruction stream. These are: entering a called frame, returning from one, rotating the window by an immediate, restoring the window from the saved pointer, and checking the stack-move precondition. It also performs the check made before a register access, which detects that live frames must first be spilled.

The operation and its operands are presented for one cycle. During that cycle the unit reports, combinationally, any exception request, the computed return address, and the values to save when it traps: the old pointer for the processor status and the PC for the exception PC. The pointer and the mask update at the next rising clock edge. Register storage and the stack-pointer write performed on entry live outside the unit.

Top module: `win_ctrl_unit`

## Requirements
- R1: A synchronous active-low reset sets the window pointer to 0 and the occupancy mask to only bit 0 set.
- R2: Entry and return raise exception kind 1 (illegal) and leave the state unchanged unless the overflow-enable status bit is 1 and the exception-mode status bit is 0. Under the same condition, the overflow check does nothing.
- R3: Entry (op 1) with a register selector above 3 raises kind 1. Otherwise it adds the call increment to the pointer and sets the mask bit at the new pointer.
- R4: The overflow check (op 6) searches n = 1 up to the requested span (0 to 3) for the first set mask bit at pointer+n. If none is found, it raises nothing and changes nothing.
- R5: When the overflow check finds n, it adds n to the pointer and asserts the trap-save output. The saved-pointer output then equals the old pointer and the saved-PC output equals the PC.
- R6: With m = pointer+n, the overflow kind is 3 (four registers) if mask bit m+1 is set, else 4 (eight) if bit m+2 is set, else 5 (twelve).
- R7: Return (op 2) takes the caller size n from a0[31:30]. It finds m as 1, 2 or 3 for the first set mask bit at pointer-1, -2 or -3, or 0 if none is set. It raises kind 1 if n is 0, or if m is nonzero and differs from n.
- R8: A legal return asserts the return-valid output, subtracts n from the pointer, and outputs the return address PC[31:30] joined with a0[29:0].
- R9: After the return rotation, if the mask bit at the new pointer is set, the return clears the old pointer's mask bit. Otherwise it asserts trap-save and raises kind 6, 7 or 8 for n = 1, 2 or 3, with the mask unchanged.
- R10: The stack-move check (op 5) raises kind 2 when the mask bits at pointer-1, -2 and -3 are all clear.
- R11: Rotate (op 3) adds the signed 4-bit immediate to the pointer.
- R12: Restore (op 4) loads the pointer from the saved-pointer status input.
- R13: All pointer and mask index arithmetic wraps modulo the number of window positions (physical registers / 4).
- R14: Opcodes 0 and 7 leave the pointer and mask unchanged and raise nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Operation: 0 none, 1 entry, 2 return, 3 rotate, 4 restore, 5 stack-move check, 6 overflow check, 7 none |
| pc_i | input | 32 | PC of the operation |
| a0_i | input | 32 | Return-address register value |
| sel_i | input | 4 | Register selector of entry |
| rot_imm_i | input | 4 | Signed rotate amount |
| span_i | input | 2 | Window count for the overflow check |
| ps_woe_i | input | 1 | Overflow-enable status bit |
| ps_excm_i | input | 1 | Exception-mode status bit |
| ps_callinc_i | input | 2 | Call increment status field |
| ps_owb_i | input | IW | Saved pointer status field |
| win_base_o | output | IW | Window pointer |
| win_start_o | output | NPOS | Occupancy mask |
| exc_req_o | output | 1 | Exception request |
| exc_kind_o | output | 4 | 0 none, 1 illegal, 2 alloca, 3/4/5 overflow 4/8/12, 6/7/8 underflow 4/8/12 |
| ret_ok_o | output | 1 | Return accepted |
| ret_pc_o | output | 32 | Return address |
| trap_save_o | output | 1 | Write saved pointer, set exception mode, write exception PC |
| owb_o | output | IW | Pointer value to save |
| epc_o | output | 32 | PC value to save |

## Verification
A corrupted pointer or mask bit cannot be seen on an idle cycle. It becomes visible at the next window operation that reads it: the kind of overflow or underflow changes, a legal return becomes illegal, or a stack-move check raises a spurious alloca. The pointer and mask ports reflect the damage one edge after the faulty update, and the exception outputs reflect it in the same cycle as the next dependent operation. The vector table therefore chains operations so that each one depends on the state left by the one before it.

// File: rtl/wcu_pkg.sv
// Shared encodings of the register window control unit.
// Assumes: operation and exception codes are fixed by the block's ports.
package wcu_pkg;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_ENTRY   = 3'd1,
        OP_RETURN  = 3'd2,
        OP_ROTATE  = 3'd3,
        OP_RESTORE = 3'd4,
        OP_STKCHK  = 3'd5,
        OP_OVFCHK  = 3'd6,
        OP_RSVD    = 3'd7
    } wcu_op_e;

    typedef enum logic [3:0] {
        EXC_NONE    = 4'd0,
        EXC_ILLEGAL = 4'd1,
        EXC_ALLOCA  = 4'd2,
        EXC_OVF4    = 4'd3,
        EXC_OVF8    = 4'd4,
        EXC_OVF12   = 4'd5,
        EXC_UNF4    = 4'd6,
        EXC_UNF8    = 4'd7,
        EXC_UNF12   = 4'd8
    } wcu_exc_e;

endpackage

// File: rtl/wcu_ring_tap.sv
// Reads NTAP mask bits at base+1..base+NTAP (UPWARD=1) or at
// base-1..base-NTAP (UPWARD=0), with indices wrapping modulo NPOS.
// Assumes: NPOS is a power of two equal to 2**IW.
module wcu_ring_tap #(
    parameter int NPOS   = 16,
    parameter int IW     = 4,
    parameter int NTAP   = 3,
    parameter bit UPWARD = 1'b1
) (
    input  logic [NPOS-1:0] ring_i,
    input  logic [IW-1:0]   base_i,
    output logic [NTAP-1:0] tap_o
);

    for (genvar k = 0; k < NTAP; k++) begin : g_tap
        localparam logic [IW-1:0] DIST = IW'(k + 1);
        if (UPWARD) begin : g_up
            // tap k looks k+1 positions above the base
            assign tap_o[k] = ring_i[base_i + DIST];
        end else begin : g_down
            // tap k looks k+1 positions below the base
            assign tap_o[k] = ring_i[base_i - DIST];
        end
    end

endmodule

// File: rtl/wcu_fwd_scan.sv
// Overflow search: finds the first set mask bit within span positions
// above the pointer and classifies the spill size from the two bits after it.
// Assumes: tap_i[j] is the mask bit at pointer+j+1.
module wcu_fwd_scan
    import wcu_pkg::*;
(
    input  logic [4:0] tap_i,
    input  logic [1:0] span_i,
    output logic       hit_o,
    output logic [1:0] dist_o,
    output wcu_exc_e   kind_o
);

    // first hit among distances 1..span
    always_comb begin
        hit_o  = 1'b0;
        dist_o = 2'd0;
        for (int j = 0; j < 3; j++) begin
            if (!hit_o && (j < int'(span_i)) && tap_i[j]) begin
                hit_o  = 1'b1;
                dist_o = 2'(j + 1);
            end
        end
    end

    // spill size from the bits one and two past the hit
    always_comb begin
        if (tap_i[dist_o])
            kind_o = EXC_OVF4;
        else if (tap_i[3'(dist_o) + 3'd1])
            kind_o = EXC_OVF8;
        else
            kind_o = EXC_OVF12;
    end

endmodule

// File: rtl/wcu_back_scan.sv
// Caller-size search: reports 1, 2 or 3 for the nearest set mask bit below
// the pointer, or 0 when none of the three is set.
// Assumes: tap_i[j] is the mask bit at pointer-j-1.
module wcu_back_scan (
    input  logic [2:0] tap_i,
    output logic [1:0] size_o
);

    // priority to the nearest frame below
    always_comb begin
        if (tap_i[0])      size_o = 2'd1;
        else if (tap_i[1]) size_o = 2'd2;
        else if (tap_i[2]) size_o = 2'd3;
        else               size_o = 2'd0;
    end

endmodule

// File: rtl/win_ctrl_unit.sv
// Register window control unit: owns the window pointer and occupancy mask,
// executes one window operation per cycle and reports exceptions, the return
// address and trap save values combinationally; state updates at the edge.
// Assumes: NUM_PHYS_REGS is 32 or 64.
module win_ctrl_unit
    import wcu_pkg::*;
#(
    parameter int NUM_PHYS_REGS = 64,
    localparam int NPOS = NUM_PHYS_REGS / 4,
    localparam int IW   = $clog2(NPOS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      op_i,
    input  logic [31:0]     pc_i,
    input  logic [31:0]     a0_i,
    input  logic [3:0]      sel_i,
    input  logic [3:0]      rot_imm_i,
    input  logic [1:0]      span_i,
    input  logic            ps_woe_i,
    input  logic            ps_excm_i,
    input  logic [1:0]      ps_callinc_i,
    input  logic [IW-1:0]   ps_owb_i,
    output logic [IW-1:0]   win_base_o,
    output logic [NPOS-1:0] win_start_o,
    output logic            exc_req_o,
    output logic [3:0]      exc_kind_o,
    output logic            ret_ok_o,
    output logic [31:0]     ret_pc_o,
    output logic            trap_save_o,
    output logic [IW-1:0]   owb_o,
    output logic [31:0]     epc_o
);

    logic [IW-1:0]   base_q, base_d;
    logic [NPOS-1:0] start_q, start_d;
    logic [4:0]      fwd_tap;
    logic [2:0]      back_tap;
    logic            ovf_hit;
    logic [1:0]      ovf_dist;
    wcu_exc_e        ovf_kind;
    logic [1:0]      caller_sz;
    logic [IW-1:0]   rot_w;
    logic [1:0]      ret_n;
    logic            legal;
    wcu_op_e         op;
    wcu_exc_e        kind;

    assign op    = wcu_op_e'(op_i);
    assign ret_n = a0_i[31:30];
    assign legal = ps_woe_i & ~ps_excm_i;

    // rotate immediate brought to pointer width (modular add)
    if (IW == 3) begin : g_imm3
        assign rot_w = rot_imm_i[2:0];
    end else begin : g_imm4
        assign rot_w = {{(IW-4){rot_imm_i[3]}}, rot_imm_i};
    end

    wcu_ring_tap #(.NPOS(NPOS), .IW(IW), .NTAP(5), .UPWARD(1'b1)) u_fwd_tap (
        .ring_i (start_q),
        .base_i (base_q),
        .tap_o  (fwd_tap)
    );

    wcu_ring_tap #(.NPOS(NPOS), .IW(IW), .NTAP(3), .UPWARD(1'b0)) u_back_tap (
        .ring_i (start_q),
        .base_i (base_q),
        .tap_o  (back_tap)
    );

    wcu_fwd_scan u_fwd_scan (
        .tap_i  (fwd_tap),
        .span_i (span_i),
        .hit_o  (ovf_hit),
        .dist_o (ovf_dist),
        .kind_o (ovf_kind)
    );

    wcu_back_scan u_back_scan (
        .tap_i  (back_tap),
        .size_o (caller_sz)
    );

    // operation decode: next state and per-cycle results
    always_comb begin
        base_d      = base_q;
        start_d     = start_q;
        kind        = EXC_NONE;
        ret_ok_o    = 1'b0;
        trap_save_o = 1'b0;
        unique case (op)
            OP_ENTRY: begin
                if (sel_i > 4'd3 || !legal) begin
                    kind = EXC_ILLEGAL;
                end else begin
                    base_d          = base_q + {{(IW-2){1'b0}}, ps_callinc_i};
                    start_d[base_d] = 1'b1;
                end
            end
            OP_RETURN: begin
                if (!legal || ret_n == 2'd0 || (caller_sz != 2'd0 && caller_sz != ret_n)) begin
                    kind = EXC_ILLEGAL;
                end else begin
                    ret_ok_o = 1'b1;
                    base_d   = base_q - {{(IW-2){1'b0}}, ret_n};
                    if (start_q[base_d]) begin
                        start_d[base_q] = 1'b0;
                    end else begin
                        trap_save_o = 1'b1;
                        kind = (ret_n == 2'd1) ? EXC_UNF4 :
                               (ret_n == 2'd2) ? EXC_UNF8 : EXC_UNF12;
                    end
                end
            end
            OP_ROTATE:  base_d = base_q + rot_w;
            OP_RESTORE: base_d = ps_owb_i;
            OP_STKCHK: begin
                if (caller_sz == 2'd0) kind = EXC_ALLOCA;
            end
            OP_OVFCHK: begin
                if (legal && ovf_hit) begin
                    base_d      = base_q + {{(IW-2){1'b0}}, ovf_dist};
                    trap_save_o = 1'b1;
                    kind        = ovf_kind;
                end
            end
            default: ;
        endcase
    end

    // window state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            start_q <= {{(NPOS-1){1'b0}}, 1'b1};
        end else begin
            base_q  <= base_d;
            start_q <= start_d;
        end
    end

    assign win_base_o  = base_q;
    assign win_start_o = start_q;
    assign exc_kind_o  = kind;
    assign exc_req_o   = (kind != EXC_NONE);
    assign ret_pc_o    = {pc_i[31:30], a0_i[29:0]};
    assign owb_o       = base_q;
    assign epc_o       = pc_i;

    AST_ILLEGAL_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_kind_o == EXC_ILLEGAL |=> $stable(win_base_o) && $stable(win_start_o)); // R2
    AST_ENTRY_MARKS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ENTRY && !exc_req_o) |=> win_start_o[win_base_o]); // R3
    AST_SAVE_ONLY_ON_WINDOW_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        trap_save_o |-> exc_kind_o >= EXC_OVF4); // R5
    AST_RETURN_CLEARS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_RETURN && ret_ok_o && !exc_req_o) |=> !win_start_o[$past(win_base_o)]); // R9
    AST_UNDERFLOW_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        exc_kind_o >= EXC_UNF4 |=> $stable(win_start_o)); // R9
    AST_RESTORE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_RESTORE |=> win_base_o == $past(ps_owb_i)); // R12
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_NOP || op_i == OP_RSVD) |=> $stable(win_base_o) && $stable(win_start_o)); // R14

endmodule

// File: tb/win_ctrl_unit_bench.sv
// Bench for the register window control unit: a chained vector table, then
// directed idle and reset tests. Default configuration: 16 window positions.
module win_ctrl_unit_bench;

    localparam int NPOS = 16;
    localparam int IW   = 4;

    typedef struct packed {
        logic [2:0]  op;
        logic [3:0]  sel;
        logic [3:0]  imm;
        logic [1:0]  span;
        logic [1:0]  n;
        logic        woe;
        logic        excm;
        logic [1:0]  ci;
        logic [3:0]  owb;
        logic [3:0]  kind;
        logic        rok;
        logic        sv;
        logic [3:0]  wb;
        logic [15:0] ws;
    } vec_t;

    // op,sel,imm,span,n,woe,excm,ci,owb | kind,rok,save,wb after,mask after
    localparam int NV = 36;
    localparam vec_t TBL [NV] = '{
        '{3'd1,4'd0,4'h0,2'd0,2'd0,1'b1,1'b0,2'd2,4'h0, 4'd0,1'b0,1'b0,4'd2, 16'h0005},
        '{3'd5,4'd0,4'h0,2'd0,2'd0,1'b1,1'b0,2'd0,4'h0, 4'd0,1'b0,1'b0,4'd2, 16'h0005},
        '{3'd3,4'd0,4'hD,2'd0,2'd0,1'b1,1'b0,2'd0,4'h0, 4'd0,1'b0,1'b0,4'd15,16'h0005},
        '{3'd6,4'd0,4'h0,2'd3,2'd0,1'b1,1'b0,2'd0,4'h0, 4'd4,1'b0,1'b1,4'd0, 16'h0005},
        '{3'd1,4'd3,4'h0,2'd0,2'd0,1'b1,1'b0,2'd1,4'h0, 4'd0,1'b0,1'b0,4'd1, 16'h0007},
        '{3'd3,4'd0,4'hF,2'd0,2'd0,1'b1,1'b0,2'd0,4'h0, 4'd0,1'b0,1'b0,4'd0, 16'h0007},
        '{3'd6,4'd0,4'h0,2'd3,2'd0,1'b1,1'b0,2'd0,4'h0, 4'd3,1'b0,1'b1,4'd1, 16'h0007},
        '{3'd3,4'd0,4'h8,2'd0,2'd0,1'b1,1'b0,2'd0,4'h0, 4'd0,1'b0,1'b0,4'd9, 16'h0007},
        '{3'd6,4'd0,4'h0,2'd3,2'd0,1'b1,1'b0,2'd0,4'h0, 4'd0,1'b0,1'b0,4'd9, 16'h0007},
        '{3'd3,4'd0,4'h7,2'd0,2'd0,1'b1,1'b0,2'd0,4'h0, 4'd0,1'b0,1'b0,4'd0, 16'h0007},
        '{3'd6,4'd0,4'h0,2'd0,2'd0,1'b1,1'b0,2'd0,4'h0, 4'd0,1'b0,1'b0,4'd0, 16'h0007},
        '{3'd2,4'd0,4'h0,2'd0,2'd1,1'b1,1'b0,2'd0,4'h0, 4'd6,1'b1,1'b1,4'd15,16'h0007},
        '{3'd4,4'd0,4'h0,2'd0,2'd0,1'b1,1'b0,2'd0,4'h0, 4'd0,1'b0,1'b0,4'd0, 16'h0007},
        '{3'd1,4'd0,4'h0,2'd0,2'd0,1'b1,1'b0,2'd3,4'h0, 4'd0,1'b0,1'b0,4'd3, 16'h000F},
        '{3'd2,4'd0,4'h0,2'd0,2'd3,1'b1,1'b0,2'd0,4'h0, 4'd1,1'b0,1'b0,4'd3, 16'h000F},
        '{3'd2,4'd0,4'h0,2'd0,2'd1,1'b1,1'b0,2'd0,4'h0, 4'd0,1'b1,1'b0,4'd2, 16'h0007},
        '{3'd2,4'd0,4'h0,2'd0,2'd2,1'b1,1'b0,2'd0,4'h0, 4'd1,1'b0,1'b0,4'd2, 16'h0007},
        '{3'd2,4'd0,4'h0,2'd0,2'd1,1'b0,1'b0,2'd0,4'h0, 4'd1,1'b0,1'b0,4'd2, 16'h0007},
        '{3'd1,4'd0,4'h0,2'd0,2'd0,1'b1,1'b1,2'd1,4'h0, 4'd1,1'b0,1'b0,4'd2, 16'h0007},
        '{3'd1,4'd4,4'h0,2'd0,2'd0,1'b1,1'b0,2'd1,4'h0, 4'd1,1'b0,1'b0,4'd2, 16'h0007},
        '{3'd3,4'd0,4'hF,2'd0,2'd0,1'b1,1'b0,2'd0,4'h0, 4'd0,1'b0,1'b0,4'd1, 16'h0007},
        '{3'd6,4'd0,4'h0,2'd3,2'd0,1'b1,1'b1,2'd0,4'h0, 4'd0,1'b0,1'b0,4'd1, 16'h0007},
        '{3'd6,4'd0,4'h0,2'd3,2'd0,1'b0,1'b0,2'd0,4'h0, 4'd0,1'b0,1'b0,4'd1, 16'h0007},
        '{3'd3,4'd0,4'h7,2'd0,2'd0,1'b1,1'b0,2'd0,4'h0, 4'd0,1'b0,1'b0,4'd8, 16'h0007},
        '{3'd2,4'd0,4'h0,2'd0,2'd2,1'b1,1'b0,2'd0,4'h0, 4'd7,1'b1,1'b1,4'd6, 16'h0007},
        '{3'd3,4'd0,4'h2,2'd0,2'd0,1'b1,1'b0,2'd0,4'h0, 4'd0,1'b0,1'b0,4'd8, 16'h0007},
        '{3'd2,4'd0,4'h0,2'd0,2'd3,1'b1,1'b0,2'd0,4'h0, 4'd8,1'b1,1'b1,4'd5, 16'h0007},
        '{3'd3,4'd0,4'h4,2'd0,2'd0,1'b1,1'b0,2'd0,4'h0, 4'd0,1'b0,1'b0,4'd9, 16'h0007},
        '{3'd5,4'd0,4'h0,2'd0,2'd0,1'b1,1'b0,2'd0,4'h0, 4'd2,1'b0,1'b0,4'd9, 16'h0007},
        '{3'd3,4'd0,4'h4,2'd0,2'd0,1'b1,1'b0,2'd0,4'h0, 4'd0,1'b0,1'b0,4'd13,16'h0007},
        '{3'd1,4'd0,4'h0,2'd0,2'd0,1'b1,1'b0,2'd2,4'h0, 4'd0,1'b0,1'b0,4'd15,16'h8007},
        '{3'd1,4'd0,4'h0,2'd0,2'd0,1'b1,1'b0,2'd3,4'h0, 4'd0,1'b0,1'b0,4'd2, 16'h8007},
        '{3'd3,4'd0,4'hE,2'd0,2'd0,1'b1,1'b0,2'd0,4'h0, 4'd0,1'b0,1'b0,4'd0, 16'h8007},
        '{3'd2,4'd0,4'h0,2'd0,2'd1,1'b1,1'b0,2'd0,4'h0, 4'd0,1'b1,1'b0,4'd15,16'h8006},
        '{3'd4,4'd0,4'h0,2'd0,2'd0,1'b1,1'b0,2'd0,4'hA, 4'd0,1'b0,1'b0,4'd10,16'h8006},
        '{3'd1,4'd2,4'h0,2'd0,2'd0,1'b1,1'b0,2'd0,4'h0, 4'd0,1'b0,1'b0,4'd10,16'h8406}
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic [2:0]      op_i;
    logic [31:0]     pc_i, a0_i;
    logic [3:0]      sel_i, rot_imm_i;
    logic [1:0]      span_i, ps_callinc_i;
    logic            ps_woe_i, ps_excm_i;
    logic [IW-1:0]   ps_owb_i;
    logic [IW-1:0]   win_base_o, owb_o;
    logic [NPOS-1:0] win_start_o;
    logic            exc_req_o, ret_ok_o, trap_save_o;
    logic [3:0]      exc_kind_o;
    logic [31:0]     ret_pc_o, epc_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    win_ctrl_unit u_win_ctrl_unit (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .pc_i(pc_i), .a0_i(a0_i),
        .sel_i(sel_i), .rot_imm_i(rot_imm_i), .span_i(span_i),
        .ps_woe_i(ps_woe_i), .ps_excm_i(ps_excm_i), .ps_callinc_i(ps_callinc_i),
        .ps_owb_i(ps_owb_i), .win_base_o(win_base_o), .win_start_o(win_start_o),
        .exc_req_o(exc_req_o), .exc_kind_o(exc_kind_o), .ret_ok_o(ret_ok_o),
        .ret_pc_o(ret_pc_o), .trap_save_o(trap_save_o), .owb_o(owb_o), .epc_o(epc_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic string req_of(input vec_t v);
        if (!v.woe || v.excm)  return "R2 gating";
        case (v.op)
            3'd1: return "R3 entry";
            3'd2: return (v.kind == 4'd1) ? "R7 return legality" :
                         (v.kind >= 4'd6) ? "R9 underflow" : "R8 return";
            3'd3: return "R11 rotate / R13 wrap";
            3'd4: return "R12 restore";
            3'd5: return "R10 stack-move check";
            3'd6: return (v.kind >= 4'd3) ? "R6 overflow kind" : "R4 overflow search";
            default: return "R14 idle";
        endcase
    endfunction

    task automatic idle_inputs();
        op_i = 3'd0; pc_i = '0; a0_i = '0; sel_i = '0; rot_imm_i = '0;
        span_i = '0; ps_woe_i = 1'b1; ps_excm_i = 1'b0; ps_callinc_i = '0; ps_owb_i = '0;
    endtask

    // watchdog: an expired run is a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] prev_wb;
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset base", 32'(win_base_o), 32'd0);
        chk("R1 reset mask", 32'(win_start_o), 32'h0001);
        chk("R1 reset no exception", 32'(exc_req_o), 32'd0);
        rst_n = 1'b1;
        prev_wb = 4'd0;

        for (int i = 0; i < NV; i++) begin
            vec_t  v;
            string rq;
            v  = TBL[i];
            rq = req_of(v);
            op_i = v.op; sel_i = v.sel; rot_imm_i = v.imm; span_i = v.span;
            ps_woe_i = v.woe; ps_excm_i = v.excm; ps_callinc_i = v.ci; ps_owb_i = v.owb;
            pc_i = {2'(i), 30'h0000_1000 + 30'(i * 4)};
            a0_i = {v.n, 30'h0ABC_DE00 + 30'(i)};
            #2;
            chk(rq, 32'(exc_kind_o), 32'(v.kind));
            chk(rq, 32'(exc_req_o), 32'(v.kind != 4'd0));
            chk(rq, 32'(ret_ok_o), 32'(v.rok));
            chk("R5 trap save", 32'(trap_save_o), 32'(v.sv));
            if (v.sv) begin
                chk("R5 saved pointer", 32'(owb_o), 32'(prev_wb));
                chk("R5 saved pc", epc_o, pc_i);
            end
            if (v.rok) chk("R8 return address", ret_pc_o, {pc_i[31:30], a0_i[29:0]});
            @(posedge clk);
            #2;
            chk(rq, 32'(win_base_o), 32'(v.wb));
            chk(rq, 32'(win_start_o), 32'(v.ws));
            prev_wb = v.wb;
            @(negedge clk);
        end

        // R14: idle opcodes 0 and 7 hold state
        idle_inputs();
        op_i = 3'd7; rot_imm_i = 4'h5; ps_owb_i = 4'h3; sel_i = 4'd1; ps_callinc_i = 2'd1;
        #2;
        chk("R14 reserved op no exception", 32'(exc_req_o), 32'd0);
        @(posedge clk); #2;
        chk("R14 reserved op base", 32'(win_base_o), 32'd10);
        chk("R14 reserved op mask", 32'(win_start_o), 32'h8406);
        @(negedge clk);
        op_i = 3'd0;
        @(posedge clk); #2;
        chk("R14 nop base", 32'(win_base_o), 32'd10);
        chk("R14 nop mask", 32'(win_start_o), 32'h8406);

        // R1: synchronous reset mid-run overrides a pending entry
        @(negedge clk);
        op_i = 3'd1; ps_callinc_i = 2'd1; sel_i = 4'd0;
        rst_n = 1'b0;
        @(posedge clk); #2;
        chk("R1 mid-run reset base", 32'(win_base_o), 32'd0);
        chk("R1 mid-run reset mask", 32'(win_start_o), 32'h0001);
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b1;

        // R10: stack-move check right after reset finds no caller frame
        op_i = 3'd5;
        #2;
        chk("R10 alloca after reset", 32'(exc_kind_o), 32'd2);
        @(negedge clk);
        idle_inputs();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule